// File: doc/BRIEF.md
# Bidirectional Dual-Mode Sampling Sequencer

This block is the digital scan control for a sampling driver with 80 groups of three channels (A, B, C), which makes 240 strobe outputs. A start pulse is registered on the rising edge of the shift clock. The block then walks registered one-hot sample strobes across the outputs. In group mode, the three channels of one group fire together and the scan advances one group per clock. In channel mode, it advances one channel per clock, and the first strobe arrives three clock periods after the start is captured.

A direction input chooses between two arrangements. With direction high, the first start pin is the input, the scan runs upward, and the second pin drives the cascade pulse for a chained device. With direction low, the roles of the two pins are swapped and the scan runs downward. Each shared pin is modelled as a separate input, output and output-enable. When the final strobe has been issued, the block parks in standby and ignores the clock until a new start is captured.

Top module: `scan_strobe_seq`

## Requirements
- R1: The active start pin is `start_a_i` when `dir_i`=1 and `start_b_i` when `dir_i`=0. A high level on the other pin starts nothing.
- R2: Group mode (`mode_i`=1): on the first clock edge after the capture edge, strobe bits 3g, 3g+1 and 3g+2 of the first group g go high together for one cycle.
- R3: In group mode, groups follow one per clock with no gap. The order is g=0 up to 79 when direction is up and g=79 down to 0 when direction is down.
- R4: Channel mode (`mode_i`=0): the first strobe goes high on the third clock edge after the capture edge. The two edges in between produce no strobe.
- R5: In channel mode, exactly one bit is high per clock, and bit index = 3*group + channel (A=0, B=1, C=2). The index runs 0,1,...,239 when direction is up and 239,238,...,0 when direction is down.
- R6: After the final strobe, all strobes stay low on every later clock until a new start is captured.
- R7: At most three strobe bits are high in any cycle.
- R8: The cascade pulse is high for exactly the cycle in which the final strobe is high. It appears on `cascade_b_o` for a scan started with direction up and on `cascade_a_o` for a scan started with direction down. At all other times both cascade outputs are low.
- R9: `cascade_b_oe` equals `dir_i` and `cascade_a_oe` equals the inverse of `dir_i`, combinationally.
- R10: Mode and direction are sampled at the capture edge. Changing them during a scan does not alter that scan.
- R11: A start seen on any edge while a scan is pending or running is ignored, including the edge that issues the final strobe. A start present on the first edge in standby is captured.
- R12: A low `rst_n` at a clock edge forces standby, with all strobes and both cascade outputs low after that edge, and aborts any scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1 = group mode, 0 = channel mode |
| dir_i | input | 1 | 1 = upward scan, 0 = downward scan |
| start_a_i | input | 1 | Input side of shared pin A |
| start_b_i | input | 1 | Input side of shared pin B |
| cascade_a_o | output | 1 | Output side of shared pin A |
| cascade_a_oe | output | 1 | Output enable of shared pin A |
| cascade_b_o | output | 1 | Output side of shared pin B |
| cascade_b_oe | output | 1 | Output enable of shared pin B |
| strobe_o | output | 240 | Sample strobes, bit 3*group+channel |

## Verification
Two events can fall in the same cycle. The final strobe coincides with the cascade pulse, and the edge that issues the final strobe can also see a new start. The bench holds a start level across the end of a scan and also places single start pulses exactly on the final edge and one edge later. A queue-based reference model predicts every cycle, so the bench can judge whether the restart is delayed to the first standby edge and whether the cascade pulse lines up with the last strobe.

// File: rtl/scan_strobe_pkg.sv
package scan_strobe_pkg;

   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_LEAD = 2'd1,
      SS_RUN  = 2'd2
   } ss_state_e;

   function automatic int unsigned width_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/scan_strobe_start_sel.sv
module scan_strobe_start_sel (
   input  logic dir_i,
   input  logic start_a_i,
   input  logic start_b_i,
   output logic start_o,
   output logic oe_a_o,
   output logic oe_b_o
);

   // direction high: pin A listens, pin B drives
   always_comb begin
      start_o = dir_i ? start_a_i : start_b_i;
      oe_b_o  = dir_i;
      oe_a_o  = ~dir_i;
   end

endmodule

// File: rtl/scan_strobe_ctrl.sv
module scan_strobe_ctrl
   import scan_strobe_pkg::*;
#(
   parameter int unsigned NUM_GROUPS   = 80,
   parameter int unsigned CH_PER_GROUP = 3,
   parameter int unsigned SEQ_LATENCY  = 3,
   localparam int unsigned GW = width_for(NUM_GROUPS),
   localparam int unsigned CW = width_for(CH_PER_GROUP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_i,
   input  logic          dir_i,
   output logic          fire_o,
   output logic          last_o,
   output logic [GW-1:0] grp_o,
   output logic [CW-1:0] ch_o,
   output logic          grp_mode_o,
   output logic          up_o
);

   localparam int unsigned LW = width_for(SEQ_LATENCY);
   localparam logic [GW-1:0] GRP_LAST = GW'(NUM_GROUPS - 1);
   localparam logic [CW-1:0] CH_LAST  = CW'(CH_PER_GROUP - 1);

   initial begin
      assert (NUM_GROUPS >= 2) else $fatal(1, "NUM_GROUPS must be at least 2");
      assert (CH_PER_GROUP >= 1) else $fatal(1, "CH_PER_GROUP must be at least 1");
      assert (SEQ_LATENCY >= 1) else $fatal(1, "SEQ_LATENCY must be at least 1");
   end

   ss_state_e     state_q;
   logic [GW-1:0] grp_q;
   logic [CW-1:0] ch_q;
   logic          grp_mode_q;
   logic          up_q;
   logic [LW-1:0] lead_q;
   logic          lead_done;

   logic grp_top, grp_bot, ch_top, ch_bot, last;

   always_comb begin
      grp_top = (grp_q == GRP_LAST);
      grp_bot = (grp_q == '0);
      ch_top  = (ch_q == CH_LAST);
      ch_bot  = (ch_q == '0);
      if (grp_mode_q)
         last = up_q ? grp_top : grp_bot;
      else
         last = up_q ? (grp_top && ch_top) : (grp_bot && ch_bot);
   end

   // lead-in counter variant chosen by latency parameter
   generate
      if (SEQ_LATENCY > 1) begin : g_lead
         always_comb lead_done = (lead_q == '0);
      end else begin : g_nolead
         always_comb lead_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SS_IDLE;
         grp_q      <= '0;
         ch_q       <= '0;
         grp_mode_q <= 1'b0;
         up_q       <= 1'b1;
         lead_q     <= '0;
      end else begin
         case (state_q)
            SS_IDLE: begin
               if (start_i) begin
                  grp_mode_q <= mode_i;
                  up_q       <= dir_i;
                  grp_q      <= dir_i ? '0 : GRP_LAST;
                  ch_q       <= dir_i ? '0 : CH_LAST;
                  lead_q     <= LW'((SEQ_LATENCY > 1) ? SEQ_LATENCY - 2 : 0);
                  if (mode_i || SEQ_LATENCY == 1)
                     state_q <= SS_RUN;
                  else
                     state_q <= SS_LEAD;
               end
            end
            SS_LEAD: begin
               if (lead_done)
                  state_q <= SS_RUN;
               else
                  lead_q <= lead_q - 1'b1;
            end
            SS_RUN: begin
               if (last) begin
                  state_q <= SS_IDLE;
               end else if (grp_mode_q) begin
                  grp_q <= up_q ? grp_q + 1'b1 : grp_q - 1'b1;
               end else if (up_q) begin
                  if (ch_top) begin
                     ch_q  <= '0;
                     grp_q <= grp_q + 1'b1;
                  end else begin
                     ch_q <= ch_q + 1'b1;
                  end
               end else begin
                  if (ch_bot) begin
                     ch_q  <= CH_LAST;
                     grp_q <= grp_q - 1'b1;
                  end else begin
                     ch_q <= ch_q - 1'b1;
                  end
               end
            end
            default: state_q <= SS_IDLE;
         endcase
      end
   end

   always_comb begin
      fire_o     = (state_q == SS_RUN);
      last_o     = last;
      grp_o      = grp_q;
      ch_o       = ch_q;
      grp_mode_o = grp_mode_q;
      up_o       = up_q;
   end

endmodule

// File: rtl/scan_strobe_dec.sv
module scan_strobe_dec
   import scan_strobe_pkg::*;
#(
   parameter int unsigned NUM_GROUPS   = 80,
   parameter int unsigned CH_PER_GROUP = 3,
   localparam int unsigned GW = width_for(NUM_GROUPS),
   localparam int unsigned CW = width_for(CH_PER_GROUP),
   localparam int unsigned NS = NUM_GROUPS * CH_PER_GROUP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire_i,
   input  logic          last_i,
   input  logic [GW-1:0] grp_i,
   input  logic [CW-1:0] ch_i,
   input  logic          grp_mode_i,
   input  logic          up_i,
   output logic [NS-1:0] strobe_o,
   output logic          casc_up_o,
   output logic          casc_dn_o
);

   logic [NS-1:0] hit;
   logic [NS-1:0] strobe_q;
   logic          casc_up_q, casc_dn_q;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         logic grp_hit;
         assign grp_hit = fire_i && (grp_i == GW'(g));
         for (genvar c = 0; c < CH_PER_GROUP; c++) begin : g_ch
            assign hit[g*CH_PER_GROUP + c] = grp_hit && (grp_mode_i || (ch_i == CW'(c)));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q  <= '0;
         casc_up_q <= 1'b0;
         casc_dn_q <= 1'b0;
      end else begin
         strobe_q  <= hit;
         casc_up_q <= fire_i && last_i && up_i;
         casc_dn_q <= fire_i && last_i && !up_i;
      end
   end

   assign strobe_o  = strobe_q;
   assign casc_up_o = casc_up_q;
   assign casc_dn_o = casc_dn_q;

endmodule

// File: rtl/scan_strobe_seq.sv
module scan_strobe_seq
   import scan_strobe_pkg::*;
#(
   parameter int unsigned NUM_GROUPS   = 80,
   parameter int unsigned CH_PER_GROUP = 3,
   parameter int unsigned SEQ_LATENCY  = 3,
   localparam int unsigned NS = NUM_GROUPS * CH_PER_GROUP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_i,
   input  logic          dir_i,
   input  logic          start_a_i,
   input  logic          start_b_i,
   output logic          cascade_a_o,
   output logic          cascade_a_oe,
   output logic          cascade_b_o,
   output logic          cascade_b_oe,
   output logic [NS-1:0] strobe_o
);

   localparam int unsigned GW = width_for(NUM_GROUPS);
   localparam int unsigned CW = width_for(CH_PER_GROUP);

   logic          start_w;
   logic          fire_w, last_w, grp_mode_w, up_w;
   logic [GW-1:0] grp_w;
   logic [CW-1:0] ch_w;
   logic          casc_up_w, casc_dn_w;

   scan_strobe_start_sel sel_i (
      .dir_i     (dir_i),
      .start_a_i (start_a_i),
      .start_b_i (start_b_i),
      .start_o   (start_w),
      .oe_a_o    (cascade_a_oe),
      .oe_b_o    (cascade_b_oe)
   );

   scan_strobe_ctrl #(
      .NUM_GROUPS   (NUM_GROUPS),
      .CH_PER_GROUP (CH_PER_GROUP),
      .SEQ_LATENCY  (SEQ_LATENCY)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .mode_i     (mode_i),
      .dir_i      (dir_i),
      .fire_o     (fire_w),
      .last_o     (last_w),
      .grp_o      (grp_w),
      .ch_o       (ch_w),
      .grp_mode_o (grp_mode_w),
      .up_o       (up_w)
   );

   scan_strobe_dec #(
      .NUM_GROUPS   (NUM_GROUPS),
      .CH_PER_GROUP (CH_PER_GROUP)
   ) dec_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire_w),
      .last_i     (last_w),
      .grp_i      (grp_w),
      .ch_i       (ch_w),
      .grp_mode_i (grp_mode_w),
      .up_i       (up_w),
      .strobe_o   (strobe_o),
      .casc_up_o  (casc_up_w),
      .casc_dn_o  (casc_dn_w)
   );

   // upward scan hands off on pin B, downward scan on pin A
   assign cascade_b_o = casc_up_w;
   assign cascade_a_o = casc_dn_w;

endmodule

// File: rtl/scan_strobe_checker.sv
module scan_strobe_checker #(
   parameter int unsigned CH_PER_GROUP = 3,
   parameter int unsigned NS = 240
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cascade_a_o,
   input logic          cascade_b_o,
   input logic [NS-1:0] strobe_o
);

   a_r7_strobe_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(strobe_o) <= CH_PER_GROUP);

   a_r8_cascade_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_a_o || cascade_b_o) |=> !(cascade_a_o || cascade_b_o));

   a_r8_cascade_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_a_o || cascade_b_o) |-> (strobe_o != '0));

   a_r8_cascade_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cascade_a_o && cascade_b_o));

   a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ((strobe_o != '0) && !cascade_a_o && !cascade_b_o) |=> (strobe_o != '0));

   a_r12_reset_clears: assert property (@(posedge clk)
      !rst_n |=> ((strobe_o == '0) && !cascade_a_o && !cascade_b_o));

endmodule

bind scan_strobe_seq scan_strobe_checker #(
   .CH_PER_GROUP (CH_PER_GROUP),
   .NS           (NS)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cascade_a_o (cascade_a_o),
   .cascade_b_o (cascade_b_o),
   .strobe_o    (strobe_o)
);

// File: tb/scan_strobe_seq_tb_top.sv
module scan_strobe_seq_tb_top;

   localparam int NG  = 80;
   localparam int CPG = 3;
   localparam int NS  = NG * CPG;
   localparam int WAIT_ITEM = -1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_i = 1'b1, dir_i = 1'b1, start_a_i = 1'b0, start_b_i = 1'b0;
   logic cascade_a_o, cascade_a_oe, cascade_b_o, cascade_b_oe;
   logic [NS-1:0] strobe_o;

   int errors = 0;
   int checks = 0;
   string cur_tag = "R12";
   bit done = 1'b0;

   always #4 clk = ~clk;

   scan_strobe_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
      .start_a_i(start_a_i), .start_b_i(start_b_i),
      .cascade_a_o(cascade_a_o), .cascade_a_oe(cascade_a_oe),
      .cascade_b_o(cascade_b_o), .cascade_b_oe(cascade_b_oe),
      .strobe_o(strobe_o)
   );

   // reference model: item >= 1000 is group (item-1000), else channel index
   int q[$];
   bit cur_up = 1'b1;
   logic [NS-1:0] exp_strobe = '0;
   logic exp_ca = 1'b0, exp_cb = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         exp_strobe = '0; exp_ca = 1'b0; exp_cb = 1'b0;
      end else begin
         int item;
         bit busy;
         bit st;
         busy = (q.size() != 0);
         st = dir_i ? start_a_i : start_b_i;
         exp_strobe = '0; exp_ca = 1'b0; exp_cb = 1'b0;
         if (busy) begin
            item = q.pop_front();
            if (item >= 1000) begin
               for (int c = 0; c < CPG; c++) exp_strobe[(item-1000)*CPG + c] = 1'b1;
            end else if (item >= 0) begin
               exp_strobe[item] = 1'b1;
            end
            if (q.size() == 0) begin
               exp_cb = cur_up;
               exp_ca = !cur_up;
            end
         end else if (st) begin
            cur_up = dir_i;
            if (mode_i) begin
               for (int g = 0; g < NG; g++) q.push_back(1000 + (dir_i ? g : NG-1-g));
            end else begin
               q.push_back(WAIT_ITEM);
               q.push_back(WAIT_ITEM);
               for (int i = 0; i < NS; i++) q.push_back(dir_i ? i : NS-1-i);
            end
         end
      end
   end

   task automatic check_bit(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (strobe_o !== exp_strobe) begin
            errors++;
            $display("FAIL %s strobe actual=%h expected=%h at %0t", cur_tag, strobe_o, exp_strobe, $time);
         end
         check_bit(cur_tag, "cascade_a", cascade_a_o, exp_ca);
         check_bit(cur_tag, "cascade_b", cascade_b_o, exp_cb);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic pulse_start(bit pin_a);
      if (pin_a) start_a_i = 1'b1; else start_b_i = 1'b1;
      step(1);
      start_a_i = 1'b0; start_b_i = 1'b0;
   endtask

   initial begin
      step(3);
      cur_tag = "R12";
      check_bit("R12", "reset strobe zero", (strobe_o == '0), 1'b1);
      rst_n = 1'b1;
      step(2);

      // R9: output enables follow direction
      dir_i = 1'b1; #1;
      check_bit("R9", "oe_b dir=1", cascade_b_oe, 1'b1);
      check_bit("R9", "oe_a dir=1", cascade_a_oe, 1'b0);
      dir_i = 1'b0; #1;
      check_bit("R9", "oe_b dir=0", cascade_b_oe, 1'b0);
      check_bit("R9", "oe_a dir=0", cascade_a_oe, 1'b1);

      // R1: inactive pin does nothing
      cur_tag = "R1";
      dir_i = 1'b0; start_a_i = 1'b1; step(5); start_a_i = 1'b0;
      dir_i = 1'b1; start_b_i = 1'b1; step(5); start_b_i = 1'b0;
      step(2);

      // R2/R3/R8: group scan up, then standby R6
      cur_tag = "R2"; mode_i = 1'b1; dir_i = 1'b1;
      pulse_start(1'b1);
      step(1);
      cur_tag = "R3"; step(NG);
      cur_tag = "R6"; step(10);

      // group scan down with mode/dir toggled mid-scan (R10)
      cur_tag = "R3"; dir_i = 1'b0;
      pulse_start(1'b0);
      cur_tag = "R10"; mode_i = 1'b0; dir_i = 1'b1; step(20);
      mode_i = 1'b1; dir_i = 1'b0; cur_tag = "R8"; step(NG);
      cur_tag = "R6"; step(5);

      // R4/R5: channel scan up with extra start pulses mid-scan (R11)
      cur_tag = "R4"; mode_i = 1'b0; dir_i = 1'b1;
      pulse_start(1'b1);
      step(4);
      cur_tag = "R11"; pulse_start(1'b1); step(30); pulse_start(1'b1);
      cur_tag = "R5"; step(NS);
      cur_tag = "R6"; step(6);

      // channel scan down; start held across the end (R11 restart)
      cur_tag = "R5"; dir_i = 1'b0;
      pulse_start(1'b0);
      step(NS - 5);
      cur_tag = "R11"; mode_i = 1'b1; start_b_i = 1'b1;
      step(12); start_b_i = 1'b0;
      step(NG + 5);

      // single pulse exactly on a final edge (group up)
      cur_tag = "R11"; dir_i = 1'b1; mode_i = 1'b1;
      pulse_start(1'b1);
      step(NG - 1);
      pulse_start(1'b1);          // lands on final-strobe edge: ignored
      step(3);
      pulse_start(1'b1);          // accepted
      step(NG + 3);

      // R12: reset mid-scan
      cur_tag = "R12"; mode_i = 1'b0;
      pulse_start(1'b1);
      step(20);
      rst_n = 1'b0; step(2);
      rst_n = 1'b1; step(8);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule